// File: doc/BRIEF.md
# Set-Associative Cache Bank with Pooled Reserve Ways

This block is one bank of a set-associative cache. Each set keeps a few of its ways back as reserve storage. Neighbouring sets are grouped, and each group pools the reserve slots of its member sets. A small set-associative side directory records which block lives in each pooled slot. It holds one directory set per group, with one entry per pooled slot. Each entry stores the block tag, a valid bit, the member set that owns the block, and the physical slot it occupies. The data array is modelled as one word per block.

A request carries an address, a read/write flag and write data. The home set's normal tags and the group's directory are searched in the same cycle. A match in a normal way is a direct hit and answers one cycle after acceptance. A miss is detected in that same cycle. A directory match needs a second array access, so the answer takes two cycles and the port stalls in between. After an indirect hit the block swaps with a normal-way block of its home set. On a miss, the displaced normal-way block is moved into a free pooled slot, or into the group's next round-robin entry when the pool is full. Refill from the next level is not modelled: a read miss installs a zero word.

The controller has two states. In `ST_IDLE` the port is ready, and a request moves to `ST_SECOND` on the accept-indirect transition. Accept-direct and accept-miss keep the controller in `ST_IDLE`. `ST_SECOND` performs the second access and the swap, then takes the swap-done transition back to `ST_IDLE`.

Top module: `cbr_bank`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, all three counters are 0, and every tag entry is invalid, so the first access to any address misses.
- R2: Address fields are offset [5:0] (ignored), set [8:6] and tag [35:9]. A direct hit answers with kind 2'b01 one cycle after acceptance. A read returns the stored word and a write replaces it.
- R3: A miss answers with kind 2'b11 in the same cycle a direct hit would. A read miss returns zero and installs the block with a zero word. A write miss installs the block with the write data.
- R4: An indirect hit answers with kind 2'b10 two cycles after acceptance. `req_ready` is 0 in the cycle between, and a read returns the block's word.
- R5: A miss fills the lowest invalid normal way of the home set. If no way is invalid, it takes the set's round-robin way, and the valid block it displaces moves into the group's pooled reserve, from where it later hits indirectly.
- R6: A pooled block hits only for its own home set. The same tag requested through a fellow set of the group misses.
- R7: A block displaced on a miss takes a free directory entry first. When all entries of the group are valid, it takes the group's next round-robin entry. The block dropped this way misses on its next access.
- R8: After an indirect hit the block hits directly. The normal-way block it displaced now hits indirectly. Data written on an indirect hit is kept.
- R9: Each response increments exactly the counter of its kind, so the miss count equals the number of requests minus both hit counts.
- R10: With no request presented, no response appears, and only one request is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_addr | input | 36 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_kind | output | 2 | 01 direct, 10 indirect, 11 miss |
| rsp_rdata | output | 32 | Read word (block word before any write) |
| cnt_direct | output | 16 | Direct-hit count |
| cnt_indirect | output | 16 | Indirect-hit count |
| cnt_miss | output | 16 | Miss count |

## Verification
The assertions assume a requester that treats a request as taken only when `req_valid` and `req_ready` are both high. They also assume that no address matches more than one normal way or more than one directory entry, which the install and swap paths maintain. The bench keeps to this by issuing one request at a time. It raises `req_valid` only while the bank is idle and drops it at the falling edge after acceptance. The directed sequences fill, overflow and swap specific sets so that every way and directory entry is in a known position before each check.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    typedef enum logic [1:0] {
        KIND_NONE     = 2'b00,
        KIND_DIRECT   = 2'b01,
        KIND_INDIRECT = 2'b10,
        KIND_MISS     = 2'b11
    } hit_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SECOND = 1'b1
    } bank_state_e;

endpackage

// File: rtl/cbr_normal_tags.sv
module cbr_normal_tags #(
    parameter int SETS  = 8,
    parameter int NWAYS = 6,
    parameter int TAG_W = 27,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    output logic [WAY_W-1:0] vic_way,
    output logic             vic_full,
    output logic [TAG_W-1:0] vic_tag,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_adv
);

    logic [TAG_W-1:0] tags [SETS][NWAYS];
    logic [NWAYS-1:0] vld  [SETS];
    logic [WAY_W-1:0] ptr  [SETS];
    logic [NWAYS-1:0] hit_vec;
    logic [WAY_W-1:0] inv_way;
    logic             inv_found;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld[lk_set][w] && (tags[lk_set][w] == lk_tag);
    end

    always_comb begin
        lk_way    = '0;
        inv_way   = '0;
        inv_found = 1'b0;
        for (int w = 0; w < NWAYS; w++) begin
            if (hit_vec[w]) lk_way = WAY_W'(w);
            if (!inv_found && !vld[lk_set][w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
    end

    assign lk_hit   = |hit_vec;
    assign vic_full = &vld[lk_set];
    assign vic_way  = vic_full ? ptr[lk_set] : inv_way;
    assign vic_tag  = tags[lk_set][vic_way];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld[s] <= '0;
                ptr[s] <= '0;
            end
        end else if (wr_en) begin
            vld[wr_set][wr_way] <= 1'b1;
            if (wr_adv)
                ptr[wr_set] <= (ptr[wr_set] == WAY_W'(NWAYS - 1)) ? '0 : ptr[wr_set] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tags[wr_set][wr_way] <= wr_tag;
    end

    // R2: a tag lives in at most one normal way of its set
    p_single_way_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R5: installs only target existing normal ways
    p_way_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_way) < NWAYS));

endmodule

// File: rtl/cbr_reserve_tags.sv
module cbr_reserve_tags #(
    parameter int GROUPS = 4,
    parameter int ENTS   = 4,
    parameter int TAG_W  = 27,
    parameter int FEL    = 2,
    localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int ENT_W = (ENTS > 1) ? $clog2(ENTS) : 1,
    localparam int FEL_W = (FEL > 1) ? $clog2(FEL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] lk_grp,
    input  logic [FEL_W-1:0] lk_fel,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [ENT_W-1:0] lk_ent,
    output logic [ENT_W-1:0] lk_slot,
    output logic [ENT_W-1:0] al_ent,
    output logic             al_full,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [ENT_W-1:0] wr_ent,
    input  logic             wr_vld,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [FEL_W-1:0] wr_fel,
    input  logic [ENT_W-1:0] wr_slot,
    input  logic             wr_drop
);

    logic [TAG_W-1:0] e_tag  [GROUPS][ENTS];
    logic [FEL_W-1:0] e_fel  [GROUPS][ENTS];
    logic [ENT_W-1:0] e_slot [GROUPS][ENTS];
    logic [ENTS-1:0]  e_vld  [GROUPS];
    logic [ENT_W-1:0] drop_ptr [GROUPS];
    logic [ENTS-1:0]  match_vec;
    logic [ENT_W-1:0] free_ent;
    logic             free_found;

    for (genvar e = 0; e < ENTS; e++) begin : g_cmp
        assign match_vec[e] = e_vld[lk_grp][e]
                           && (e_tag[lk_grp][e] == lk_tag)
                           && (e_fel[lk_grp][e] == lk_fel);
    end

    always_comb begin
        lk_ent     = '0;
        free_ent   = '0;
        free_found = 1'b0;
        for (int e = 0; e < ENTS; e++) begin
            if (match_vec[e]) lk_ent = ENT_W'(e);
            if (!free_found && !e_vld[lk_grp][e]) begin
                free_found = 1'b1;
                free_ent   = ENT_W'(e);
            end
        end
    end

    assign lk_hit  = |match_vec;
    assign lk_slot = e_slot[lk_grp][lk_ent];
    assign al_full = &e_vld[lk_grp];
    assign al_ent  = al_full ? drop_ptr[lk_grp] : free_ent;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < GROUPS; g++) begin
                e_vld[g]    <= '0;
                drop_ptr[g] <= '0;
            end
        end else if (wr_en) begin
            e_vld[wr_grp][wr_ent] <= wr_vld;
            if (wr_drop)
                drop_ptr[wr_grp] <= (drop_ptr[wr_grp] == ENT_W'(ENTS - 1)) ? '0 : drop_ptr[wr_grp] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            e_tag[wr_grp][wr_ent]  <= wr_tag;
            e_fel[wr_grp][wr_ent]  <= wr_fel;
            e_slot[wr_grp][wr_ent] <= wr_slot;
        end
    end

    // R6: tag plus owner selects at most one directory entry
    p_one_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R7: a round-robin drop only replaces an entry that was valid
    p_drop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_drop) |-> e_vld[wr_grp][wr_ent]);

endmodule

// File: rtl/cbr_data.sv
module cbr_data #(
    parameter int NBLK   = 48,
    parameter int RBLK   = 16,
    parameter int DATA_W = 32,
    localparam int NI_W = $clog2(NBLK),
    localparam int RI_W = $clog2(RBLK)
) (
    input  logic              clk,
    input  logic [NI_W-1:0]   n_ridx,
    output logic [DATA_W-1:0] n_rdata,
    input  logic [RI_W-1:0]   r_ridx,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              n_we,
    input  logic [NI_W-1:0]   n_widx,
    input  logic [DATA_W-1:0] n_wdata,
    input  logic              r_we,
    input  logic [RI_W-1:0]   r_widx,
    input  logic [DATA_W-1:0] r_wdata
);

    logic [DATA_W-1:0] n_mem [NBLK];
    logic [DATA_W-1:0] r_mem [RBLK];

    assign n_rdata = n_mem[n_ridx];
    assign r_rdata = r_mem[r_ridx];

    always_ff @(posedge clk) begin
        if (n_we) n_mem[n_widx] <= n_wdata;
        if (r_we) r_mem[r_widx] <= r_wdata;
    end

endmodule

// File: rtl/cbr_bank.sv
module cbr_bank
    import cbr_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter int OFF_W  = 6,
    parameter int SET_W  = 3,
    parameter int WAYS   = 8,
    parameter int RSV    = 2,
    parameter int FEL    = 2,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [CNT_W-1:0]  cnt_direct,
    output logic [CNT_W-1:0]  cnt_indirect,
    output logic [CNT_W-1:0]  cnt_miss
);

    localparam int SETS    = 1 << SET_W;
    localparam int NWAYS   = WAYS - RSV;
    localparam int TAG_W   = ADDR_W - SET_W - OFF_W;
    localparam int FEL_LOG = $clog2(FEL);
    localparam int GROUPS  = SETS / FEL;
    localparam int GRP_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int ENTS    = RSV * FEL;
    localparam int ENT_W   = (ENTS > 1) ? $clog2(ENTS) : 1;
    localparam int FEL_W   = (FEL > 1) ? FEL_LOG : 1;
    localparam int WAY_W   = (NWAYS > 1) ? $clog2(NWAYS) : 1;
    localparam int NBLK    = SETS * NWAYS;
    localparam int RBLK    = SETS * RSV;
    localparam int NI_W    = $clog2(NBLK);
    localparam int RI_W    = $clog2(RBLK);

    function automatic logic [NI_W-1:0] nidx(input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w);
        return NI_W'(int'(s) * NWAYS + int'(w));
    endfunction

    function automatic logic [RI_W-1:0] ridx(input logic [GRP_W-1:0] g, input logic [ENT_W-1:0] e);
        return RI_W'(int'(g) * ENTS + int'(e));
    endfunction

    bank_state_e state, state_nx;

    // address decode
    logic [SET_W-1:0] a_set;
    logic [TAG_W-1:0] a_tag;
    logic [GRP_W-1:0] a_grp;
    logic [FEL_W-1:0] a_fel;
    logic             unused_off;

    assign a_set      = req_addr[OFF_W +: SET_W];
    assign a_tag      = req_addr[OFF_W + SET_W +: TAG_W];
    assign a_grp      = GRP_W'(a_set >> FEL_LOG);
    assign unused_off = ^req_addr[OFF_W-1:0];

    if (FEL > 1) begin : g_fel
        assign a_fel = a_set[FEL_W-1:0];
    end else begin : g_nofel
        assign a_fel = '0;
    end

    // lookup results
    logic             n_hit, n_vfull;
    logic [WAY_W-1:0] n_way, n_vway;
    logic [TAG_W-1:0] n_vtag;
    logic             r_hit, r_full;
    logic [ENT_W-1:0] r_ent, r_slot, r_alloc;

    // captured request for the second access
    logic [SET_W-1:0]  q_set;
    logic [TAG_W-1:0]  q_tag, q_vtag;
    logic              q_write, q_vfull;
    logic [DATA_W-1:0] q_wdata;
    logic [GRP_W-1:0]  q_grp;
    logic [FEL_W-1:0]  q_fel;
    logic [ENT_W-1:0]  q_ent, q_slot;
    logic [WAY_W-1:0]  q_vway;

    // control
    logic              accept, capture;
    hit_kind_e         kind_nx;
    logic [DATA_W-1:0] data_nx;
    logic              nt_we, nt_adv;
    logic [SET_W-1:0]  nt_set;
    logic [WAY_W-1:0]  nt_way;
    logic [TAG_W-1:0]  nt_tag;
    logic              rt_we, rt_vld, rt_drop;
    logic [GRP_W-1:0]  rt_grp;
    logic [ENT_W-1:0]  rt_ent, rt_slot;
    logic [TAG_W-1:0]  rt_tag;
    logic [FEL_W-1:0]  rt_fel;
    logic [NI_W-1:0]   dn_ridx, dn_widx;
    logic [RI_W-1:0]   dr_ridx, dr_widx;
    logic [DATA_W-1:0] dn_rdata, dr_rdata, dn_wdata, dr_wdata;
    logic              dn_we, dr_we;

    cbr_normal_tags #(.SETS(SETS), .NWAYS(NWAYS), .TAG_W(TAG_W)) i_ntags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(a_set), .lk_tag(a_tag),
        .lk_hit(n_hit), .lk_way(n_way),
        .vic_way(n_vway), .vic_full(n_vfull), .vic_tag(n_vtag),
        .wr_en(nt_we), .wr_set(nt_set), .wr_way(nt_way), .wr_tag(nt_tag), .wr_adv(nt_adv)
    );

    cbr_reserve_tags #(.GROUPS(GROUPS), .ENTS(ENTS), .TAG_W(TAG_W), .FEL(FEL)) i_rtags (
        .clk(clk), .rst_n(rst_n),
        .lk_grp(a_grp), .lk_fel(a_fel), .lk_tag(a_tag),
        .lk_hit(r_hit), .lk_ent(r_ent), .lk_slot(r_slot),
        .al_ent(r_alloc), .al_full(r_full),
        .wr_en(rt_we), .wr_grp(rt_grp), .wr_ent(rt_ent), .wr_vld(rt_vld),
        .wr_tag(rt_tag), .wr_fel(rt_fel), .wr_slot(rt_slot), .wr_drop(rt_drop)
    );

    cbr_data #(.NBLK(NBLK), .RBLK(RBLK), .DATA_W(DATA_W)) i_data (
        .clk(clk),
        .n_ridx(dn_ridx), .n_rdata(dn_rdata),
        .r_ridx(dr_ridx), .r_rdata(dr_rdata),
        .n_we(dn_we), .n_widx(dn_widx), .n_wdata(dn_wdata),
        .r_we(dr_we), .r_widx(dr_widx), .r_wdata(dr_wdata)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = accept && !n_hit && r_hit;

    always_comb begin
        state_nx = state;
        kind_nx  = KIND_NONE;
        data_nx  = '0;
        nt_we = 1'b0; nt_adv = 1'b0; nt_set = a_set; nt_way = n_vway; nt_tag = a_tag;
        rt_we = 1'b0; rt_vld = 1'b0; rt_drop = 1'b0; rt_grp = a_grp;
        rt_ent = r_alloc; rt_slot = r_alloc; rt_tag = n_vtag; rt_fel = a_fel;
        dn_ridx = nidx(a_set, n_hit ? n_way : n_vway);
        dr_ridx = ridx(a_grp, r_slot);
        dn_we = 1'b0; dn_widx = nidx(a_set, n_way); dn_wdata = req_wdata;
        dr_we = 1'b0; dr_widx = ridx(a_grp, r_alloc); dr_wdata = dn_rdata;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (n_hit) begin
                        kind_nx = KIND_DIRECT;
                        data_nx = dn_rdata;
                        dn_we   = req_write;
                    end else if (r_hit) begin
                        state_nx = ST_SECOND;
                    end else begin
                        kind_nx  = KIND_MISS;
                        nt_we    = 1'b1;
                        nt_adv   = n_vfull;
                        dn_we    = 1'b1;
                        dn_widx  = nidx(a_set, n_vway);
                        dn_wdata = req_write ? req_wdata : '0;
                        rt_we    = n_vfull;
                        rt_vld   = 1'b1;
                        rt_drop  = r_full;
                        dr_we    = n_vfull;
                    end
                end
            end
            ST_SECOND: begin
                state_nx = ST_IDLE;
                kind_nx  = KIND_INDIRECT;
                dn_ridx  = nidx(q_set, q_vway);
                dr_ridx  = ridx(q_grp, q_slot);
                data_nx  = dr_rdata;
                nt_we    = 1'b1;
                nt_adv   = q_vfull;
                nt_set   = q_set;
                nt_way   = q_vway;
                nt_tag   = q_tag;
                dn_we    = 1'b1;
                dn_widx  = nidx(q_set, q_vway);
                dn_wdata = q_write ? q_wdata : dr_rdata;
                rt_we    = 1'b1;
                rt_vld   = q_vfull;
                rt_grp   = q_grp;
                rt_ent   = q_ent;
                rt_slot  = q_slot;
                rt_tag   = q_vtag;
                rt_fel   = q_fel;
                dr_we    = q_vfull;
                dr_widx  = ridx(q_grp, q_slot);
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_kind     <= KIND_NONE;
            rsp_rdata    <= '0;
            cnt_direct   <= '0;
            cnt_indirect <= '0;
            cnt_miss     <= '0;
        end else begin
            rsp_valid <= (kind_nx != KIND_NONE);
            rsp_kind  <= kind_nx;
            rsp_rdata <= data_nx;
            if (kind_nx == KIND_DIRECT)   cnt_direct   <= cnt_direct + 1'b1;
            if (kind_nx == KIND_INDIRECT) cnt_indirect <= cnt_indirect + 1'b1;
            if (kind_nx == KIND_MISS)     cnt_miss     <= cnt_miss + 1'b1;
        end
    end

    // request capture for the indirect path
    always_ff @(posedge clk) begin
        if (capture) begin
            q_set   <= a_set;
            q_tag   <= a_tag;
            q_write <= req_write;
            q_wdata <= req_wdata;
            q_grp   <= a_grp;
            q_fel   <= a_fel;
            q_ent   <= r_ent;
            q_slot  <= r_slot;
            q_vway  <= n_vway;
            q_vfull <= n_vfull;
            q_vtag  <= n_vtag;
        end
    end

    logic [CNT_W-1:0] cnt_sum;
    assign cnt_sum = cnt_direct + cnt_indirect + cnt_miss;

    // R2: an accepted request answers next cycle unless it stalls for the second access
    p_accept_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ((rsp_valid && rsp_kind != KIND_INDIRECT) || !req_ready));

    // R4: a stall cycle is always followed by the indirect answer
    p_stall_then_ind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (rsp_valid && rsp_kind == KIND_INDIRECT));

    // R4: an indirect answer is always preceded by a stall cycle
    p_ind_after_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_INDIRECT) |-> $past(!req_ready));

    // R10: no response without an accepted request or a finished second access
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(accept) || $past(!req_ready)));

    // R9: each response moves the counter total by exactly one, otherwise it holds
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((cnt_sum - $past(cnt_sum)) == CNT_W'(1)));

    p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(cnt_sum));

endmodule

// File: tb/test_cbr_bank.sv
module test_cbr_bank;
    import cbr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [35:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [31:0] rsp_rdata;
    logic [15:0] cnt_direct, cnt_indirect, cnt_miss;

    int n_cmp = 0;
    int n_bad = 0;
    int e_dir = 0, e_ind = 0, e_miss = 0, e_req = 0;

    always #4 clk = ~clk;

    cbr_bank i_cbr_bank (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
        .cnt_direct(cnt_direct), .cnt_indirect(cnt_indirect), .cnt_miss(cnt_miss)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic [35:0] mk(input int tag, input int set, input int off = 0);
        return {27'(tag), 3'(set), 6'(off)};
    endfunction

    // one request, returns kind, data, latency and ready in the cycle after acceptance
    task automatic access(input logic [35:0] a, input logic w, input logic [31:0] d,
                          output logic [1:0] kind, output logic [31:0] rd,
                          output int lat, output logic mid_ready);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        mid_ready = req_ready;
        while (!rsp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        kind = rsp_kind;
        rd = rsp_rdata;
    endtask

    task automatic expect_acc(input string req, input int tag, input int set,
                              input logic w, input logic [31:0] d,
                              input logic [1:0] ekind, input logic [31:0] edata,
                              input int off = 0);
        logic [1:0] k; logic [31:0] rd; int lat; logic mr;
        access(mk(tag, set, off), w, d, k, rd, lat, mr);
        e_req++;
        if (ekind == KIND_DIRECT) e_dir++;
        else if (ekind == KIND_INDIRECT) e_ind++;
        else e_miss++;
        check({req, " kind"}, 64'(k), 64'(ekind));
        check({req, " latency"}, 64'(lat), (ekind == KIND_INDIRECT) ? 64'd2 : 64'd1);
        if (ekind == KIND_INDIRECT) check({req, " ready low in stall"}, 64'(mr), 64'd0);
        if (!w) check({req, " data"}, 64'(rd), 64'(edata));
    endtask

    task automatic t_reset();
        check("R1 ready after reset", 64'(req_ready), 64'd1);
        check("R1 no response after reset", 64'(rsp_valid), 64'd0);
        check("R1 counters zero", {16'd0, cnt_direct, cnt_indirect, cnt_miss}, 64'd0);
    endtask

    task automatic t_basic();
        expect_acc("R1 R3 first read misses", 1, 0, 1'b0, 0, KIND_MISS, 32'h0);
        expect_acc("R2 write direct", 1, 0, 1'b1, 32'hAA, KIND_DIRECT, 0);
        expect_acc("R2 read direct", 1, 0, 1'b0, 0, KIND_DIRECT, 32'hAA);
        expect_acc("R2 offset ignored", 1, 0, 1'b0, 0, KIND_DIRECT, 32'hAA, 42);
        expect_acc("R3 write miss", 2, 0, 1'b1, 32'h22, KIND_MISS, 0);
        expect_acc("R3 write miss installed", 2, 0, 1'b0, 0, KIND_DIRECT, 32'h22);
    endtask

    task automatic t_evict_swap();
        for (int t = 3; t <= 6; t++)
            expect_acc("R5 fill set", t, 0, 1'b1, 32'(t), KIND_MISS, 0);
        expect_acc("R5 full set miss", 7, 0, 1'b0, 0, KIND_MISS, 32'h0);
        expect_acc("R4 R5 evicted block indirect", 1, 0, 1'b0, 0, KIND_INDIRECT, 32'hAA);
        expect_acc("R8 swapped block direct", 1, 0, 1'b0, 0, KIND_DIRECT, 32'hAA);
        expect_acc("R8 displaced block indirect", 2, 0, 1'b0, 0, KIND_INDIRECT, 32'h22);
    endtask

    task automatic t_fellow();
        expect_acc("R6 fellow set misses", 3, 1, 1'b0, 0, KIND_MISS, 32'h0);
        expect_acc("R6 owner set still indirect", 3, 0, 1'b0, 0, KIND_INDIRECT, 32'h3);
    endtask

    task automatic t_drop();
        for (int t = 1; t <= 6; t++)
            expect_acc("R3 fill set 2", t, 2, 1'b1, 32'(32'h100 + t), KIND_MISS, 0);
        for (int t = 7; t <= 11; t++)
            expect_acc("R5 R7 evicting miss", t, 2, 1'b0, 0, KIND_MISS, 32'h0);
        expect_acc("R7 newest kept", 5, 2, 1'b0, 0, KIND_INDIRECT, 32'h105);
        expect_acc("R7 second kept", 2, 2, 1'b0, 0, KIND_INDIRECT, 32'h102);
        expect_acc("R7 oldest dropped", 1, 2, 1'b0, 0, KIND_MISS, 32'h0);
        expect_acc("R8 write on indirect", 3, 2, 1'b1, 32'hBEEF, KIND_INDIRECT, 0);
        expect_acc("R8 written data kept", 3, 2, 1'b0, 0, KIND_DIRECT, 32'hBEEF);
        expect_acc("R7 round-robin second drop", 7, 2, 1'b0, 0, KIND_MISS, 32'h0);
        expect_acc("R7 surviving entry", 6, 2, 1'b0, 0, KIND_INDIRECT, 32'h106);
    endtask

    task automatic t_idle();
        logic seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rsp_valid) seen = 1'b1;
        end
        check("R10 no response while idle", 64'(seen), 64'd0);
        check("R10 ready while idle", 64'(req_ready), 64'd1);
    endtask

    task automatic t_counts();
        @(negedge clk);
        check("R9 direct count", 64'(cnt_direct), 64'(e_dir));
        check("R9 indirect count", 64'(cnt_indirect), 64'(e_ind));
        check("R9 miss count", 64'(cnt_miss), 64'(e_miss));
        check("R9 misses equal requests minus hits",
              64'(cnt_miss), 64'(e_req - int'(cnt_direct) - int'(cnt_indirect)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_evict_swap();
        t_fellow();
        t_drop();
        t_idle();
        t_counts();
        report();
    end

endmodule